// File: doc/BRIEF.md
# Debug Trigger Register Bank

This block holds the machine-mode registers of a small breakpoint and watchpoint unit. A select register picks one of two address-match triggers. A control register and an address register are then reached for that trigger through a single CSR read/write port. Each trigger's stored control and address are driven out continuously to a separate comparison unit.

Control writes are not stored raw. Each field is legalized on the way in:
- The trigger kind stays fixed.
- The debug-only bit stays clear.
- Fields that are not implemented read back as zero.
- Size codes the comparator cannot honour fall back to "any size".

A one-cycle pulse per trigger tells the comparator to re-arm whenever that trigger's programming actually changes. The `XLEN` parameter selects a 32-bit or 64-bit field layout.

Top module: `trig_csr_bank`

## Requirements
- R1: After reset, the select register reads 0. Each control register reads only the kind value 2 in its top four bits, with every other bit 0. Each address register reads 0, and no re-arm pulse is high.
- R2: All XLEN bits of the select register are writable, and it reads back exactly the last value written.
- R3: The kind field occupies the top four bits of a control register (bits 31:28 or 63:60). It always reads 2 whatever is written. The bit just below it (bit 27 or 59) always reads 0.
- R4: Only the following control bits are kept from a write: bits 0, 1 and 2 (execute, store, load enables), bits 3, 4 and 6 (user, supervisor and machine privilege enables), and the size bits. Every other bit below the kind field reads 0, including bit 5 and bits 7 to 15 and 18 to 20.
- R5: The size code is {bits 22:21, bits 17:16} for XLEN=64, and {00, bits 17:16} for XLEN=32. Codes 0, 1, 2, 3 and 5 are stored as written. Any other code stores size bits of 0.
- R6: The address register stores all XLEN bits as written.
- R7: Port address 3 (the third data register) reads 0 and is reported unavailable. Addresses 0 to 2 are reported available while the select value is below 2.
- R8: While the select register holds 2 or more, control and address accesses read 0, report unavailable, and a write changes no stored value and raises no pulse.
- R9: A write that changes a trigger's stored control or address raises that trigger's re-arm output for exactly the following cycle. A write that leaves the stored value unchanged raises no pulse.
- R10: The per-trigger control and address outputs always equal what the corresponding register reads through the port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| csr_we_i | input | 1 | Write strobe for the addressed register |
| csr_addr_i | input | 2 | 0 select, 1 control, 2 address, 3 third data (absent) |
| csr_wdata_i | input | XLEN | Write data |
| csr_rdata_o | output | XLEN | Read data of the addressed register |
| csr_avail_o | output | 1 | Addressed register exists for the current selection |
| trig_ctrl_o | output | NUM_TRIG*XLEN | Stored control of every trigger, trigger 0 lowest |
| trig_addr_o | output | NUM_TRIG*XLEN | Stored address of every trigger, trigger 0 lowest |
| trig_rearm_o | output | NUM_TRIG | One-cycle change pulse per trigger |

## Verification
The assertions assume that the write strobe and address are known on every clock edge out of reset. They also assume that the kind field reaches the registers only through the legalizer. The bench drives the port on the falling edge and holds the strobe for exactly one rising edge per write, so each write lands once. It sweeps all sixteen size codes under several background bit patterns for both triggers at XLEN=64. Select values at and beyond the trigger count, the all-ones select, and repeated identical writes are all driven within that same protocol.

// File: rtl/trig_pkg.sv
package trig_pkg;
  typedef enum logic [1:0] {
    CSR_SEL  = 2'd0,
    CSR_CTRL = 2'd1,
    CSR_ADDR = 2'd2,
    CSR_AUX  = 2'd3
  } csr_sel_e;

  localparam logic [3:0] KIND_ADDR_MATCH = 4'd2;
  localparam logic [6:0] KEEP_LOW_MASK   = 7'h5f;
  localparam int         SZLO_LSB        = 16;
  localparam int         SZHI_LSB        = 21;

  function automatic logic size_code_ok(logic [3:0] code);
    return (code <= 4'd3) || (code == 4'd5);
  endfunction
endpackage

// File: rtl/trig_ctrl_legal.sv
module trig_ctrl_legal
  import trig_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] raw_i,
  output logic [XLEN-1:0] legal_o
);
  logic [3:0] code;
  logic       ok;

  generate
    if (XLEN == 64) begin : g_wide
      assign code = {raw_i[SZHI_LSB+1:SZHI_LSB], raw_i[SZLO_LSB+1:SZLO_LSB]};
    end else begin : g_narrow
      assign code = {2'b00, raw_i[SZLO_LSB+1:SZLO_LSB]};
    end
  endgenerate

  assign ok = size_code_ok(code);

  always_comb begin
    legal_o = '0;
    legal_o[XLEN-1 -: 4] = KIND_ADDR_MATCH;
    legal_o[6:0] = raw_i[6:0] & KEEP_LOW_MASK;
    if (ok) begin
      legal_o[SZLO_LSB+1:SZLO_LSB] = raw_i[SZLO_LSB+1:SZLO_LSB];
      if (XLEN == 64) legal_o[SZHI_LSB+1:SZHI_LSB] = raw_i[SZHI_LSB+1:SZHI_LSB];
    end
  end
endmodule

// File: rtl/trig_slot.sv
module trig_slot
  import trig_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_ctrl_i,
  input  logic            wr_addr_i,
  input  logic [XLEN-1:0] ctrl_d_i,
  input  logic [XLEN-1:0] addr_d_i,
  output logic [XLEN-1:0] ctrl_o,
  output logic [XLEN-1:0] addr_o,
  output logic            rearm_o
);
  localparam logic [XLEN-1:0] CTRL_RST = {KIND_ADDR_MATCH, {(XLEN-4){1'b0}}};

  logic ctrl_chg, addr_chg;

  assign ctrl_chg = wr_ctrl_i && (ctrl_d_i != ctrl_o);
  assign addr_chg = wr_addr_i && (addr_d_i != addr_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o  <= CTRL_RST;
      addr_o  <= '0;
      rearm_o <= 1'b0;
    end else begin
      if (ctrl_chg) ctrl_o <= ctrl_d_i;
      if (addr_chg) addr_o <= addr_d_i;
      rearm_o <= ctrl_chg || addr_chg;
    end
  end

  AST_KIND_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[XLEN-1 -: 4] == KIND_ADDR_MATCH && !ctrl_o[XLEN-5]); // R3
  AST_HOLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_o[5] && ctrl_o[15:7] == '0 && ctrl_o[20:18] == '0); // R4
  AST_SIZE_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    size_code_ok({(XLEN == 64) ? ctrl_o[22:21] : 2'b00, ctrl_o[17:16]})); // R5
  AST_REARM_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearm_o |-> (ctrl_o != $past(ctrl_o)) || (addr_o != $past(addr_o))); // R9
  AST_REARM_SHORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rearm_o && !ctrl_chg && !addr_chg) |=> !rearm_o); // R9
endmodule

// File: rtl/trig_csr_bank.sv
module trig_csr_bank
  import trig_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int NUM_TRIG = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     csr_we_i,
  input  logic [1:0]               csr_addr_i,
  input  logic [XLEN-1:0]          csr_wdata_i,
  output logic [XLEN-1:0]          csr_rdata_o,
  output logic                     csr_avail_o,
  output logic [NUM_TRIG*XLEN-1:0] trig_ctrl_o,
  output logic [NUM_TRIG*XLEN-1:0] trig_addr_o,
  output logic [NUM_TRIG-1:0]      trig_rearm_o
);
  localparam int IDXW = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1;

  csr_sel_e                       acc;
  logic [XLEN-1:0]                sel_q;
  logic                           in_range;
  logic [IDXW-1:0]                idx;
  logic [XLEN-1:0]                ctrl_legal;
  logic [NUM_TRIG-1:0][XLEN-1:0]  ctrl_q, addr_q;

  assign acc      = csr_sel_e'(csr_addr_i);
  assign in_range = sel_q < XLEN'(NUM_TRIG);
  assign idx      = sel_q[IDXW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= '0;
    else if (csr_we_i && acc == CSR_SEL) sel_q <= csr_wdata_i;
  end

  trig_ctrl_legal #(.XLEN(XLEN)) u_legal (
    .raw_i   (csr_wdata_i),
    .legal_o (ctrl_legal)
  );

  for (genvar t = 0; t < NUM_TRIG; t++) begin : g_slot
    logic hit;
    assign hit = csr_we_i && in_range && (idx == IDXW'(t));
    trig_slot #(.XLEN(XLEN)) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_ctrl_i (hit && acc == CSR_CTRL),
      .wr_addr_i (hit && acc == CSR_ADDR),
      .ctrl_d_i  (ctrl_legal),
      .addr_d_i  (csr_wdata_i),
      .ctrl_o    (ctrl_q[t]),
      .addr_o    (addr_q[t]),
      .rearm_o   (trig_rearm_o[t])
    );
    assign trig_ctrl_o[t*XLEN +: XLEN] = ctrl_q[t];
    assign trig_addr_o[t*XLEN +: XLEN] = addr_q[t];
  end

  always_comb begin
    csr_rdata_o = '0;
    csr_avail_o = 1'b0;
    unique case (acc)
      CSR_SEL: begin
        csr_rdata_o = sel_q;
        csr_avail_o = 1'b1;
      end
      CSR_CTRL: if (in_range) begin
        csr_rdata_o = ctrl_q[idx];
        csr_avail_o = 1'b1;
      end
      CSR_ADDR: if (in_range) begin
        csr_rdata_o = addr_q[idx];
        csr_avail_o = 1'b1;
      end
      default: ;
    endcase
  end

  AST_SEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(csr_we_i && acc == CSR_SEL) |=> $stable(sel_q)); // R2
  AST_OOR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_range |=> $stable(ctrl_q) && $stable(addr_q)); // R8
  AST_OOR_NO_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_range |=> trig_rearm_o == '0); // R8
  AST_AUX_ABSENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc == CSR_AUX |-> !csr_avail_o && csr_rdata_o == '0); // R7
endmodule

// File: tb/trig_csr_bank_bench.sv
module trig_csr_bank_bench;
  localparam int XLEN = 64;
  localparam int NT   = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            we = 1'b0;
  logic [1:0]      addr = 2'd0;
  logic [XLEN-1:0] wdata = '0;
  logic [XLEN-1:0] rdata;
  logic            avail;
  logic [NT*XLEN-1:0] ctrl_o, addr_o;
  logic [NT-1:0]   rearm;

  int errors = 0;
  int checks = 0;
  logic [XLEN-1:0] m_ctrl [NT];
  logic [XLEN-1:0] m_addr [NT];

  always #10 clk = ~clk;

  trig_csr_bank #(.XLEN(XLEN), .NUM_TRIG(NT)) u_trig_csr_bank (
    .clk_i(clk), .rst_ni(rst_n), .csr_we_i(we), .csr_addr_i(addr),
    .csr_wdata_i(wdata), .csr_rdata_o(rdata), .csr_avail_o(avail),
    .trig_ctrl_o(ctrl_o), .trig_addr_o(addr_o), .trig_rearm_o(rearm)
  );

  localparam logic [XLEN-1:0] KIND = 64'h2 << 60;

  function automatic logic [XLEN-1:0] exp_legal(logic [XLEN-1:0] w);
    int code;
    logic [XLEN-1:0] r;
    code = int'(w[22:21]) * 4 + int'(w[17:16]);
    r = KIND | (w & 64'h5f);
    if (code <= 3 || code == 5) r = r | (w & 64'h0063_0000);
    return r;
  endfunction

  task automatic chk(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [XLEN-1:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [XLEN-1:0] d, output logic av);
    addr = a;
    #1;
    d = rdata; av = avail;
  endtask

  // write and check the resulting pulse against the bench model
  task automatic wr_trig(int t, logic [1:0] a, logic [XLEN-1:0] d);
    logic [XLEN-1:0] nv;
    logic exp_p;
    nv = (a == 2'd1) ? exp_legal(d) : d;
    exp_p = (a == 2'd1) ? (nv != m_ctrl[t]) : (nv != m_addr[t]);
    wr(a, d);
    if (a == 2'd1) m_ctrl[t] = nv; else m_addr[t] = nv;
    #1;
    chk("R9 pulse", XLEN'(rearm), XLEN'(exp_p) << t);
    @(negedge clk); #1;
    chk("R9 pulse width", XLEN'(rearm), '0);
  endtask

  task automatic verify(int t, string req);
    logic [XLEN-1:0] d;
    logic av;
    rd(2'd1, d, av);
    chk(req, d, m_ctrl[t]);
    rd(2'd2, d, av);
    chk(req, d, m_addr[t]);
    chk("R10 ctrl out", ctrl_o[t*XLEN +: XLEN], m_ctrl[t]);
    chk("R10 addr out", addr_o[t*XLEN +: XLEN], m_addr[t]);
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [XLEN-1:0] d;
    logic av;
    logic [XLEN-1:0] bg [4];
    bg[0] = '0; bg[1] = '1; bg[2] = 64'h5a5a_a5a5_3c3c_c3c3; bg[3] = 64'h0f0f_f0f0_0000_0055;
    for (int t = 0; t < NT; t++) begin m_ctrl[t] = KIND; m_addr[t] = '0; end

    #45 rst_n = 1'b1;
    @(negedge clk);
    rd(2'd0, d, av);
    chk("R1 select", d, '0);
    chk("R1 pulses", XLEN'(rearm), '0);
    for (int t = 0; t < NT; t++) begin
      wr(2'd0, XLEN'(t));
      verify(t, "R1 reset value");
    end

    // R2 select readback
    foreach (bg[i]) begin
      wr(2'd0, bg[i] ^ 64'h1234);
      rd(2'd0, d, av);
      chk("R2 select", d, bg[i] ^ 64'h1234);
    end

    // R3 R4 R5 sweep of size codes with several backgrounds
    for (int t = 0; t < NT; t++) begin
      wr(2'd0, XLEN'(t));
      for (int c = 0; c < 16; c++) begin
        foreach (bg[i]) begin
          logic [XLEN-1:0] w;
          w = bg[i] & ~64'h0063_0000;
          w = w | (XLEN'(c & 3) << 16) | (XLEN'(c >> 2) << 21);
          wr_trig(t, 2'd1, w);
          verify(t, "R3 R4 R5 legalized control");
        end
      end
      wr_trig(t, 2'd1, 64'h0000_0000_0025_005f); // code 5 plus privilege, access bits
      verify(t, "R5 R6 kept");
      wr_trig(t, 2'd2, 64'hdead_beef_0000_1000 + XLEN'(t));
      verify(t, "R6 address");
      wr_trig(t, 2'd2, 64'hdead_beef_0000_1000 + XLEN'(t)); // unchanged value
      verify(t, "R9 same value");
      wr_trig(t, 2'd1, 64'h0000_0000_0025_005f);
    end

    // R7 third data register
    wr(2'd0, 64'd1);
    rd(2'd3, d, av);
    chk("R7 aux data", d, '0);
    chk("R7 aux avail", XLEN'(av), '0);
    rd(2'd1, d, av);
    chk("R7 ctrl avail", XLEN'(av), 64'd1);

    // R8 out-of-range selection
    foreach (bg[i]) begin
      logic [XLEN-1:0] s;
      s = (i == 0) ? 64'd2 : (i == 1) ? '1 : 64'd3 + XLEN'(i);
      wr(2'd0, s);
      rd(2'd1, d, av);
      chk("R8 ctrl read", d, '0);
      chk("R8 avail", XLEN'(av), '0);
      wr(2'd1, 64'h0000_0000_0003_0000);
      #1 chk("R8 no pulse", XLEN'(rearm), '0);
      wr(2'd2, 64'h77);
      #1 chk("R8 no pulse", XLEN'(rearm), '0);
      rd(2'd2, d, av);
      chk("R8 addr read", d, '0);
    end
    for (int t = 0; t < NT; t++) begin
      wr(2'd0, XLEN'(t));
      verify(t, "R8 state kept");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule